// File: doc/BRIEF.md
# Byte FIFO with Direction-Aware Transfer Request Thresholds

This block sits between the byte-wide data path of a NAND flash interface and a 32-bit processor/DMA bus. It stores up to 256 bytes in first-in first-out order. The bus side moves four bytes per access and the flash side moves one byte per access. From the current fill level it raises two request lines: an interrupt request for the processor and a transfer request for a DMA engine.

A control register selects the transfer direction and a 2-bit threshold code. It also holds separate enables for the two request lines. When data flows from flash to the bus, the block compares the stored byte count against the thresholds. When data flows from the bus to flash, it compares the free byte count. One code gives the processor and the DMA engine different levels. In the flash-write direction, two of the codes keep the DMA request silent.

The block also keeps an address counter for an auxiliary error-correction FIFO. This counter advances on a step strobe and is held at zero by a software clear bit.

Top module: `nand_fifo_trigger`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x00000000, the FIFO is empty, the error-correction address reads 0, and both request outputs are low.
- R2: Bytes leave in the order they entered. A bus word pushed carries its first byte in bits [7:0] and its last byte in bits [31:24]. A bus word popped presents the oldest byte in bits [7:0]. Pop data is valid in the cycle the pop is asserted.
- R3: The following accesses are ignored and leave the FIFO unchanged: a word push with fewer than 4 free bytes, a byte push with no free byte, a word pop with fewer than 4 stored bytes, and a byte pop on an empty FIFO. When the bus and flash sides both push in one cycle, only the bus push is considered, and the same rule applies to pops. Acceptance is judged on the level before the cycle. A push and a pop may complete in the same cycle.
- R4: With direction bit 0 (flash to bus), code 00 raises both requests at 4 or more stored bytes, code 01 at 16 or more, and code 10 at 128 or more.
- R5: With direction bit 0 and code 11, the interrupt request rises at 128 or more stored bytes and the DMA request rises at 16 or more.
- R6: With direction bit 1 (bus to flash), code 00 raises only the interrupt request at 4 or more free bytes, and code 10 raises only the interrupt request at 128 or more free bytes. The DMA request stays low under both codes. Free bytes are 256 minus stored bytes.
- R7: With direction bit 1 and code 01, both requests rise at 16 or more free bytes.
- R8: With direction bit 1 and code 11, the interrupt request rises at 128 or more free bytes and the DMA request rises at 16 or more.
- R9: Interrupt-enable bit 1 gates the interrupt request and DMA-enable bit 2 gates the DMA request, each independently of the other.
- R10: The requests follow the level. They change in the same cycle the FIFO level changes, and they fall as soon as the condition stops holding.
- R11: The error-correction address counter advances by one on each step strobe and wraps at 2^ECC_AW. While clear bit 19 is 1, the counter goes to zero on the next clock and ignores step strobes.
- R12: The control register layout is: bit 0 direction, bit 1 interrupt enable, bit 2 DMA enable, bit 19 error-correction clear, bits [21:20] threshold code. Every other bit, including bits 31 to 22, reads as 0 whatever value was written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read value |
| bus_push | input | 1 | Bus side pushes one 4-byte word |
| bus_wdata | input | 32 | Bus push data |
| bus_pop | input | 1 | Bus side pops one 4-byte word |
| bus_rdata | output | 32 | Oldest four bytes in the FIFO |
| fl_push | input | 1 | Flash side pushes one byte |
| fl_wdata | input | 8 | Flash push data |
| fl_pop | input | 1 | Flash side pops one byte |
| fl_rdata | output | 8 | Oldest byte in the FIFO |
| ecc_step | input | 1 | Advance the error-correction address counter |
| ecc_addr | output | ECC_AW | Error-correction FIFO address |
| irq_req | output | 1 | Processor interrupt request |
| dma_req | output | 1 | DMA transfer request |

## Verification
A wrong fill level shows up at the request outputs in the same cycle it arises, as long as the bench places the level next to a threshold. For this reason, every threshold is approached from one byte below, or one byte beyond, in both directions. A wrong read or write pointer cannot be seen on the request lines. It only appears in the pop data, possibly many cycles later. So every pop is compared against a byte-accurate model, and this includes draining a full FIFO after rejected overflow pushes. An error-correction counter that misses a clear shows a nonzero address one clock after the clear bit is set.

// File: rtl/nft_pkg.sv
// Package: shared field positions and types for the transfer-request FIFO.
// Assumes a 32-bit control register; positions are fixed for software.
package nft_pkg;

    localparam int CFG_DIR_BIT   = 0;
    localparam int CFG_IRQEN_BIT = 1;
    localparam int CFG_DMAEN_BIT = 2;
    localparam int CFG_ECLR_BIT  = 19;
    localparam int CFG_TRIG_LO   = 20;
    localparam int CFG_TRIG_HI   = 21;

    typedef enum logic [1:0] {
        TRG_SMALL = 2'b00,
        TRG_MID   = 2'b01,
        TRG_LARGE = 2'b10,
        TRG_SPLIT = 2'b11
    } trig_e;

    typedef struct packed {
        trig_e trig;
        logic  ecc_clr;
        logic  dma_en;
        logic  irq_en;
        logic  to_flash;
    } cfg_t;

endpackage

// File: rtl/nft_ctrl_reg.sv
// Control register: holds direction, enables, ECC clear and threshold code.
// Assumes a single write strobe; unimplemented bits read as zero.
module nft_ctrl_reg
    import nft_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output cfg_t        cfg,
    output logic [31:0] cfg_rdata
);

    // Capture the implemented fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{trig: TRG_SMALL, ecc_clr: 1'b0, dma_en: 1'b0,
                     irq_en: 1'b0, to_flash: 1'b0};
        end else if (cfg_we) begin
            cfg.trig     <= trig_e'(cfg_wdata[CFG_TRIG_HI:CFG_TRIG_LO]);
            cfg.ecc_clr  <= cfg_wdata[CFG_ECLR_BIT];
            cfg.dma_en   <= cfg_wdata[CFG_DMAEN_BIT];
            cfg.irq_en   <= cfg_wdata[CFG_IRQEN_BIT];
            cfg.to_flash <= cfg_wdata[CFG_DIR_BIT];
        end
    end

    // Assemble the read view with zeros in every unused position.
    always_comb begin
        cfg_rdata                            = '0;
        cfg_rdata[CFG_TRIG_HI:CFG_TRIG_LO]   = cfg.trig;
        cfg_rdata[CFG_ECLR_BIT]              = cfg.ecc_clr;
        cfg_rdata[CFG_DMAEN_BIT]             = cfg.dma_en;
        cfg_rdata[CFG_IRQEN_BIT]             = cfg.irq_en;
        cfg_rdata[CFG_DIR_BIT]               = cfg.to_flash;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata)); // R12

endmodule

// File: rtl/nft_ecc_addr.sv
// ECC FIFO address counter: steps on a strobe, wraps, held at zero by clear.
// Assumes the clear bit comes straight from the control register.
module nft_ecc_addr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [AW-1:0] addr
);

    // Count steps unless the software clear is active.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr <= '0;
        end else if (step) begin
            addr <= addr + AW'(1);
        end
    end

    AST_ECC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (addr == '0)); // R11

    AST_ECC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(addr)); // R11

endmodule

// File: rtl/nft_byte_fifo.sv
// Byte FIFO with a 4-byte bus port and a 1-byte flash port on each side.
// Assumes DEPTH is a power of two; bus access wins over flash access on
// the same side; acceptance uses the level before the cycle.
module nft_byte_fifo #(
    parameter int DEPTH = 256,
    parameter int WB    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wpush,
    input  logic [8*WB-1:0] wpush_data,
    input  logic            bpush,
    input  logic [7:0]      bpush_data,
    input  logic            wpop,
    input  logic            bpop,
    output logic [8*WB-1:0] wpop_data,
    output logic [7:0]      bpop_data,
    output logic [LW-1:0]   level
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] free;
    logic [LW-1:0] push_n, pop_n;

    assign free = LW'(DEPTH) - level;

    // Decide how many bytes enter this cycle.
    always_comb begin
        push_n = '0;
        if (wpush) begin
            if (free >= LW'(WB)) push_n = LW'(WB);
        end else if (bpush && free != '0) begin
            push_n = LW'(1);
        end
    end

    // Decide how many bytes leave this cycle.
    always_comb begin
        pop_n = '0;
        if (wpop) begin
            if (level >= LW'(WB)) pop_n = LW'(WB);
        end else if (bpop && level != '0) begin
            pop_n = LW'(1);
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            wp    <= wp + AW'(push_n);
            rp    <= rp + AW'(pop_n);
            level <= level + push_n - pop_n;
        end
    end

    // Store accepted bytes, lane 0 first.
    always_ff @(posedge clk) begin
        if (push_n == LW'(WB)) begin
            for (int k = 0; k < WB; k++) begin
                mem[wp + AW'(k)] <= wpush_data[8*k +: 8];
            end
        end else if (push_n == LW'(1)) begin
            mem[wp] <= bpush_data;
        end
    end

    // Present the oldest bytes to both read ports.
    for (genvar g = 0; g < WB; g++) begin : g_rd_lane
        assign wpop_data[8*g +: 8] = mem[rp + AW'(g)];
    end
    assign bpop_data = mem[rp];

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wpush && free < LW'(WB) && !wpop && !bpop) |=> $stable(level)); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wpop && level < LW'(WB) && !wpush && !bpush) |=> $stable(level)); // R3

endmodule

// File: rtl/nft_trigger.sv
// Request generator: compares stored bytes (flash-to-bus) or free bytes
// (bus-to-flash) against thresholds picked by the trigger code.
// Assumes level never exceeds DEPTH; outputs are combinational from state.
module nft_trigger
    import nft_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int TH_SMALL = 4,
    parameter int TH_MID   = 16,
    parameter int TH_LARGE = 128,
    localparam int LW      = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level,
    input  cfg_t          cfg,
    output logic          irq_req,
    output logic          dma_req
);

    logic [LW-1:0] metric, irq_thr, dma_thr;
    logic          dma_allowed;

    assign metric = cfg.to_flash ? (LW'(DEPTH) - level) : level;

    // Select per-target thresholds from the trigger code.
    always_comb begin
        unique case (cfg.trig)
            TRG_SMALL: begin irq_thr = LW'(TH_SMALL); dma_thr = LW'(TH_SMALL); end
            TRG_MID:   begin irq_thr = LW'(TH_MID);   dma_thr = LW'(TH_MID);   end
            TRG_LARGE: begin irq_thr = LW'(TH_LARGE); dma_thr = LW'(TH_LARGE); end
            default:   begin irq_thr = LW'(TH_LARGE); dma_thr = LW'(TH_MID);   end
        endcase
    end

    // DMA is muted for the small and large codes when writing flash.
    assign dma_allowed = !(cfg.to_flash &&
                           (cfg.trig == TRG_SMALL || cfg.trig == TRG_LARGE));

    assign irq_req = cfg.irq_en && (metric >= irq_thr);
    assign dma_req = cfg.dma_en && dma_allowed && (metric >= dma_thr);

    AST_DMA_MUTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.to_flash && (cfg.trig == TRG_SMALL || cfg.trig == TRG_LARGE))
        |-> !dma_req); // R6

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.irq_en |-> !irq_req); // R9

    AST_SPLIT_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.trig == TRG_SPLIT && irq_req && cfg.dma_en) |-> dma_req); // R8

endmodule

// File: rtl/nand_fifo_trigger.sv
// Top: byte FIFO between flash and bus with threshold-driven interrupt and
// DMA requests, plus the ECC FIFO address counter.
// Assumes one clock domain and a synchronous active-low reset.
module nand_fifo_trigger
    import nft_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int TH_SMALL = 4,
    parameter int TH_MID   = 16,
    parameter int TH_LARGE = 128,
    parameter int ECC_AW   = 4,
    localparam int LW      = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              bus_push,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_pop,
    output logic [31:0]       bus_rdata,
    input  logic              fl_push,
    input  logic [7:0]        fl_wdata,
    input  logic              fl_pop,
    output logic [7:0]        fl_rdata,
    input  logic              ecc_step,
    output logic [ECC_AW-1:0] ecc_addr,
    output logic              irq_req,
    output logic              dma_req
);

    cfg_t          cfg;
    logic [LW-1:0] level;

    nft_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg),
        .cfg_rdata (cfg_rdata)
    );

    nft_byte_fifo #(.DEPTH(DEPTH), .WB(4)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wpush      (bus_push),
        .wpush_data (bus_wdata),
        .bpush      (fl_push),
        .bpush_data (fl_wdata),
        .wpop       (bus_pop),
        .bpop       (fl_pop),
        .wpop_data  (bus_rdata),
        .bpop_data  (fl_rdata),
        .level      (level)
    );

    nft_trigger #(
        .DEPTH    (DEPTH),
        .TH_SMALL (TH_SMALL),
        .TH_MID   (TH_MID),
        .TH_LARGE (TH_LARGE)
    ) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (level),
        .cfg     (cfg),
        .irq_req (irq_req),
        .dma_req (dma_req)
    );

    nft_ecc_addr #(.AW(ECC_AW)) u_ecc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg.ecc_clr),
        .step  (ecc_step),
        .addr  (ecc_addr)
    );

endmodule

// File: tb/nand_fifo_trigger_bench.sv
`timescale 1ns/1ps
module nand_fifo_trigger_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus_push = 1'b0, bus_pop = 1'b0, fl_push = 1'b0, fl_pop = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [7:0]  fl_wdata = '0, fl_rdata;
    logic        ecc_step = 1'b0;
    logic [3:0]  ecc_addr;
    logic        irq_req, dma_req;

    always #4 clk = ~clk;

    nand_fifo_trigger u_nand_fifo_trigger (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .bus_push(bus_push), .bus_wdata(bus_wdata),
        .bus_pop(bus_pop), .bus_rdata(bus_rdata), .fl_push(fl_push),
        .fl_wdata(fl_wdata), .fl_pop(fl_pop), .fl_rdata(fl_rdata),
        .ecc_step(ecc_step), .ecc_addr(ecc_addr), .irq_req(irq_req),
        .dma_req(dma_req)
    );

    int    nchk = 0, nerr = 0;
    bit    done = 1'b0;
    string tag = "R2";

    // Byte-accurate reference queue.
    logic [7:0] mq [256];
    int mh = 0, mn = 0;
    logic [7:0] seq = 8'h10;

    // Vector fields: {dir, code[1:0], fill[8:0], exp_irq, exp_dma}
    localparam int NV = 20;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 2'b00, 9'd3,   1'b0, 1'b0},
        {1'b0, 2'b00, 9'd4,   1'b1, 1'b1},
        {1'b0, 2'b01, 9'd15,  1'b0, 1'b0},
        {1'b0, 2'b01, 9'd16,  1'b1, 1'b1},
        {1'b0, 2'b10, 9'd127, 1'b0, 1'b0},
        {1'b0, 2'b10, 9'd128, 1'b1, 1'b1},
        {1'b0, 2'b11, 9'd127, 1'b0, 1'b1},
        {1'b0, 2'b11, 9'd16,  1'b0, 1'b1},
        {1'b0, 2'b11, 9'd15,  1'b0, 1'b0},
        {1'b0, 2'b11, 9'd128, 1'b1, 1'b1},
        {1'b1, 2'b00, 9'd252, 1'b1, 1'b0},
        {1'b1, 2'b00, 9'd253, 1'b0, 1'b0},
        {1'b1, 2'b01, 9'd240, 1'b1, 1'b1},
        {1'b1, 2'b01, 9'd241, 1'b0, 1'b0},
        {1'b1, 2'b10, 9'd128, 1'b1, 1'b0},
        {1'b1, 2'b10, 9'd129, 1'b0, 1'b0},
        {1'b1, 2'b11, 9'd129, 1'b0, 1'b1},
        {1'b1, 2'b11, 9'd128, 1'b1, 1'b1},
        {1'b1, 2'b11, 9'd241, 1'b0, 1'b0},
        {1'b1, 2'b00, 9'd0,   1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wcfg(input logic [31:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    function automatic logic [31:0] cfgword(input logic dir, input logic [1:0] code,
                                            input logic clr, input logic ie, input logic de);
        return {10'b0, code, clr, 16'b0, de, ie, dir};
    endfunction

    // One clock of FIFO traffic; pop data is checked before the edge.
    task automatic cyc(input logic bp, input logic [31:0] bd, input logic fp,
                       input logic [7:0] fd, input logic bo, input logic fo);
        int pn, qn;
        bus_push = bp; bus_wdata = bd; fl_push = fp; fl_wdata = fd;
        bus_pop = bo; fl_pop = fo;
        #1;
        pn = 0; qn = 0;
        if (bo) begin
            if (mn >= 4) begin
                qn = 4;
                check(tag, bus_rdata, {mq[(mh+3)%256], mq[(mh+2)%256],
                                       mq[(mh+1)%256], mq[mh]});
            end
        end else if (fo && mn >= 1) begin
            qn = 1;
            check(tag, {24'b0, fl_rdata}, {24'b0, mq[mh]});
        end
        if (bp) begin
            if (256 - mn >= 4) pn = 4;
        end else if (fp && mn < 256) begin
            pn = 1;
        end
        if (pn == 4) for (int k = 0; k < 4; k++) mq[(mh+mn+k)%256] = bd[8*k +: 8];
        if (pn == 1) mq[(mh+mn)%256] = fd;
        mh = (mh + qn) % 256;
        mn = mn + pn - qn;
        @(posedge clk); @(negedge clk);
        bus_push = 0; fl_push = 0; bus_pop = 0; fl_pop = 0;
    endtask

    task automatic set_fill(input int target);
        while (mn < target) begin
            if (target - mn >= 4) cyc(1, {seq+8'd3, seq+8'd2, seq+8'd1, seq}, 0, 0, 0, 0);
            else cyc(0, 0, 1, seq, 0, 0);
            seq = seq + 8'd5;
        end
        while (mn > target) begin
            if (mn - target >= 4) cyc(0, 0, 0, 0, 1, 0);
            else cyc(0, 0, 0, 0, 0, 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", cfg_rdata, 32'h0);
        check("R1", {30'b0, irq_req, dma_req}, 32'h0);
        check("R1", {28'b0, ecc_addr}, 32'h0);

        // R12 register layout and reserved bits
        wcfg(32'hFFFF_FFFF);
        check("R12", cfg_rdata, 32'h0038_0007);
        wcfg(32'h0);
        check("R12", cfg_rdata, 32'h0);

        // R2 ordering with mixed word and byte traffic
        tag = "R2";
        cyc(1, 32'h4433_2211, 0, 0, 0, 0);
        cyc(0, 0, 1, 8'h55, 0, 0);
        cyc(0, 0, 1, 8'h66, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);
        // R3 pop on empty ignored, then a fresh byte comes out first
        tag = "R3";
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 1, 8'h5A, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);
        // R3 bus push wins over flash push
        cyc(1, 32'hD4C3_B2A1, 1, 8'hEE, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 1);
        // R3 bus pop wins over flash pop; simultaneous push and pop
        cyc(1, 32'h0807_0605, 0, 0, 0, 0);
        cyc(1, 32'h0C0B_0A09, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 1, 0);
        // R3 overflow ignored, drain and compare every byte
        set_fill(256);
        cyc(1, 32'hDEAD_BEEF, 0, 0, 0, 0);
        cyc(0, 0, 1, 8'hEE, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        set_fill(0);
        cyc(0, 0, 1, 8'h77, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);

        // R4 to R8 threshold table
        tag = "R2";
        for (int i = 0; i < NV; i++) begin
            logic [13:0] v;
            string rq;
            v = VEC[i];
            if (!v[13]) rq = (v[12:11] == 2'b11) ? "R5" : "R4";
            else if (v[12:11] == 2'b01) rq = "R7";
            else if (v[12:11] == 2'b11) rq = "R8";
            else rq = "R6";
            wcfg(cfgword(v[13], v[12:11], 1'b0, 1'b1, 1'b1));
            set_fill(int'(v[10:2]));
            check({rq, " irq"}, {31'b0, irq_req}, {31'b0, v[1]});
            check({rq, " dma"}, {31'b0, dma_req}, {31'b0, v[0]});
        end

        // R9 enables gate each request separately
        set_fill(4);
        wcfg(cfgword(1'b0, 2'b00, 1'b0, 1'b0, 1'b1));
        check("R9", {30'b0, irq_req, dma_req}, 32'h1);
        wcfg(cfgword(1'b0, 2'b00, 1'b0, 1'b1, 1'b0));
        check("R9", {30'b0, irq_req, dma_req}, 32'h2);

        // R10 requests drop in the cycle the level falls below threshold
        wcfg(cfgword(1'b0, 2'b00, 1'b0, 1'b1, 1'b1));
        check("R10", {30'b0, irq_req, dma_req}, 32'h3);
        cyc(0, 0, 0, 0, 0, 1);
        check("R10", {30'b0, irq_req, dma_req}, 32'h0);
        cyc(0, 0, 1, 8'h99, 0, 0);
        check("R10", {30'b0, irq_req, dma_req}, 32'h3);

        // R11 ECC address counter
        wcfg(32'h0);
        ecc_step = 1'b1;
        repeat (5) @(negedge clk);
        ecc_step = 1'b0;
        check("R11", {28'b0, ecc_addr}, 32'd5);
        wcfg(cfgword(1'b0, 2'b00, 1'b1, 1'b0, 1'b0));
        ecc_step = 1'b1;
        @(negedge clk);
        check("R11", {28'b0, ecc_addr}, 32'd0);
        repeat (3) @(negedge clk);
        ecc_step = 1'b0;
        check("R11", {28'b0, ecc_addr}, 32'd0);
        wcfg(32'h0);
        ecc_step = 1'b1;
        repeat (17) @(negedge clk);
        ecc_step = 1'b0;
        check("R11", {28'b0, ecc_addr}, 32'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule